// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a register-mapped mailbox between a host processor and an auxiliary microcontroller. The host sees a 32-bit register port. Through it the host loads up to four words of input data and two pointer words, then writes a packed command word. Accepting that word starts a transaction: the block latches the command, marks itself busy, and raises a level interrupt toward the controller.

The controller side exposes the latched command, the pointers and the input words. The controller fills four reply words and ends the transaction with a one-cycle done strobe that carries an error flag and an 8-bit error code. The host polls the status word until busy clears. It then inspects the error fields and reads the reply words. If the command asked for it, a one-cycle host interrupt marks completion.

All controls are plain level or strobe pins. No data stream crosses the edge of the block, so there is no valid/ready back-pressure. A write is taken in the cycle it is presented. A read returns data one cycle after it is requested.

Top module: `ipc_mbox`

## Requirements
- R1: After reset every register reads as zero, `c_busy`, `c_irq` and `h_irq` are low, and `h_rdata` is zero.
- R2: A full-word host write to byte offset 0x00 while idle is accepted at that clock edge. From the next cycle `c_cmd` holds the written word, `c_busy` is high, and status bit 0 reads 1. Command word fields are: code [7:0], completion-interrupt request bit 8, sub-id [15:12], input size [23:16].
- R3: A `c_done` strobe while busy clears busy at that edge. It loads status bit 1 from `c_err`, bits [7:4] from the command sub-id, bits [15:8] from parameter INITIATOR_ID, and bits [23:16] from `c_err_code`. Bits [31:24] and bit 3 read zero.
- R4: `c_irq` rises when a command is accepted and stays high until a `c_irq_ack` pulse clears it at the next edge.
- R5: If bit 8 of the accepted command was set, `h_irq` is high for exactly the one cycle after the done edge. Otherwise it stays low.
- R6: A command write while busy is dropped: `c_cmd` is unchanged. It sets sticky status bit 2, which only reset clears.
- R7: Host writes with any byte enable low change no register (buffers, pointers, command).
- R8: Reads of the command offset, of any unmapped word offset, and of any non-word-aligned address return zero.
- R9: Host writes to the status offset (0x04) and to the reply words (0x90–0x9C) have no effect.
- R10: The pointers sit at 0x08 (source) and 0x0C (destination). Input words sit at 0x80–0x8C and reply words at 0x90–0x9C. Host reads return what was last written, and the controller pins reflect them.
- R11: `h_rdata` updates only at the edge where `h_rd_en` is high, and otherwise holds its value.
- R12: A `c_done` strobe while idle changes no status field and produces no `h_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr_en | input | 1 | Host write strobe |
| h_rd_en | input | 1 | Host read strobe |
| h_addr | input | ADDR_W | Host byte address |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, one cycle after the read |
| h_irq | output | 1 | Completion pulse toward the host |
| c_irq | output | 1 | Level interrupt toward the controller |
| c_irq_ack | input | 1 | Controller interrupt acknowledge |
| c_busy | output | 1 | Transaction in progress |
| c_cmd | output | 32 | Latched command word |
| c_sptr | output | 32 | Source pointer |
| c_dptr | output | 32 | Destination pointer |
| c_wbuf_idx | input | IDX_W | Input word select |
| c_wbuf_data | output | 32 | Selected input word |
| c_rbuf_we | input | 1 | Reply word write strobe |
| c_rbuf_idx | input | IDX_W | Reply word select |
| c_rbuf_wdata | input | 32 | Reply word data |
| c_done | input | 1 | Completion strobe |
| c_err | input | 1 | Error flag, sampled with done |
| c_err_code | input | 8 | Error code, sampled with done |

## Verification
Every host write and every controller strobe takes effect at the clock edge where it is presented. Registered host reads appear one edge after `h_rd_en`, and `h_irq` is high for the single cycle after the done edge.

The bench drives inputs on falling edges. It drops each strobe on the next falling edge and samples there, so each check lands exactly one edge after its cause. Status is always checked through a read, which adds that one cycle of latency. A sweep covers every sub-id, both settings of the completion-interrupt bit and every unmapped word offset.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

  localparam int unsigned WORD_CMD  = 0;
  localparam int unsigned WORD_STAT = 1;
  localparam int unsigned WORD_SPTR = 2;
  localparam int unsigned WORD_DPTR = 3;
  localparam int unsigned WORD_WBUF = 32;

  typedef struct packed {
    logic [7:0] rsv_hi;
    logic [7:0] in_size;
    logic [3:0] sub_id;
    logic [2:0] rsv_lo;
    logic       ioc;
    logic [7:0] code;
  } cmd_word_t;

  typedef struct packed {
    logic [7:0] rsv_hi;
    logic [7:0] err_code;
    logic [7:0] init_id;
    logic [3:0] cmd_id;
    logic       rsv3;
    logic       overrun;
    logic       err;
    logic       busy;
  } stat_word_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CMD, SEL_STAT, SEL_SPTR, SEL_DPTR, SEL_WBUF, SEL_RBUF
  } sel_t;

endpackage

// File: rtl/ipc_mbox_decode.sv
module ipc_mbox_decode
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_WORDS = 4,
  localparam int unsigned IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned WA       = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [WA-1:0] W_CMD   = WA'(WORD_CMD);
  localparam logic [WA-1:0] W_STAT  = WA'(WORD_STAT);
  localparam logic [WA-1:0] W_SPTR  = WA'(WORD_SPTR);
  localparam logic [WA-1:0] W_DPTR  = WA'(WORD_DPTR);
  localparam logic [WA-1:0] W_WB    = WA'(WORD_WBUF);
  localparam logic [WA-1:0] W_RB    = WA'(WORD_WBUF + NUM_WORDS);
  localparam logic [WA-1:0] W_RBEND = WA'(WORD_WBUF + 2 * NUM_WORDS);

  logic [WA-1:0] word;
  logic          aligned;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (aligned) begin
      if (word == W_CMD)       sel = SEL_CMD;
      else if (word == W_STAT) sel = SEL_STAT;
      else if (word == W_SPTR) sel = SEL_SPTR;
      else if (word == W_DPTR) sel = SEL_DPTR;
      else if (word >= W_WB && word < W_RB) begin
        sel = SEL_WBUF;
        idx = IDX_W'(word - W_WB);
      end else if (word >= W_RB && word < W_RBEND) begin
        sel = SEL_RBUF;
        idx = IDX_W'(word - W_RB);
      end
    end
  end
endmodule

// File: rtl/ipc_mbox_buf.sv
module ipc_mbox_buf #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_idx,
  input  logic [DW-1:0]             wr_data,
  output logic [DEPTH-1:0][DW-1:0]  words
);
  logic [DEPTH-1:0][DW-1:0] mem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      for (int i = 0; i < int'(DEPTH); i++) begin
        if (wr_en && wr_idx == IW'(i)) mem_q[i] <= wr_data;
      end
    end
  end

  assign words = mem_q;
endmodule

// File: rtl/ipc_mbox_ctrl.sv
module ipc_mbox_ctrl
  import ipc_mbox_pkg::*;
#(
  parameter logic [7:0] INITIATOR_ID = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  input  logic        done,
  input  logic        err,
  input  logic [7:0]  err_code,
  input  logic        irq_ack,
  output cmd_word_t   cmd_q,
  output stat_word_t  stat_q,
  output logic        busy,
  output logic        ctl_irq,
  output logic        host_irq
);
  logic accept;
  logic finish;

  assign accept = cmd_wr && !stat_q.busy;
  assign finish = done && stat_q.busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      stat_q   <= '0;
      ctl_irq  <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      host_irq <= finish && cmd_q.ioc;
      if (accept) begin
        cmd_q       <= cmd_word_t'(cmd_wdata);
        stat_q.busy <= 1'b1;
      end
      if (cmd_wr && stat_q.busy) stat_q.overrun <= 1'b1;
      if (finish) begin
        stat_q.busy     <= 1'b0;
        stat_q.err      <= err;
        stat_q.err_code <= err_code;
        stat_q.cmd_id   <= cmd_q.sub_id;
        stat_q.init_id  <= INITIATOR_ID;
      end
      if (accept)       ctl_irq <= 1'b1;
      else if (irq_ack) ctl_irq <= 1'b0;
    end
  end

  assign busy = stat_q.busy;
endmodule

// File: rtl/ipc_mbox.sv
module ipc_mbox
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned NUM_WORDS    = 4,
  parameter logic [7:0]  INITIATOR_ID = 8'h5A,
  localparam int unsigned IDX_W       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr_en,
  input  logic              h_rd_en,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [3:0]        h_be,
  input  logic [31:0]       h_wdata,
  output logic [31:0]       h_rdata,
  output logic              h_irq,
  output logic              c_irq,
  input  logic              c_irq_ack,
  output logic              c_busy,
  output logic [31:0]       c_cmd,
  output logic [31:0]       c_sptr,
  output logic [31:0]       c_dptr,
  input  logic [IDX_W-1:0]  c_wbuf_idx,
  output logic [31:0]       c_wbuf_data,
  input  logic              c_rbuf_we,
  input  logic [IDX_W-1:0]  c_rbuf_idx,
  input  logic [31:0]       c_rbuf_wdata,
  input  logic              c_done,
  input  logic              c_err,
  input  logic [7:0]        c_err_code
);
  sel_t                        sel;
  logic [IDX_W-1:0]            idx;
  logic                        full_wr;
  cmd_word_t                   cmd_q;
  stat_word_t                  stat_q;
  logic [NUM_WORDS-1:0][31:0]  wbuf_words;
  logic [NUM_WORDS-1:0][31:0]  rbuf_words;
  logic [31:0]                 sptr_q, dptr_q;

  assign full_wr = h_wr_en && (&h_be);

  ipc_mbox_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_dec (
    .addr(h_addr), .sel(sel), .idx(idx)
  );

  ipc_mbox_ctrl #(.INITIATOR_ID(INITIATOR_ID)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(full_wr && sel == SEL_CMD), .cmd_wdata(h_wdata),
    .done(c_done), .err(c_err), .err_code(c_err_code), .irq_ack(c_irq_ack),
    .cmd_q(cmd_q), .stat_q(stat_q), .busy(c_busy),
    .ctl_irq(c_irq), .host_irq(h_irq)
  );

  ipc_mbox_buf #(.DEPTH(NUM_WORDS), .DW(32)) u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(full_wr && sel == SEL_WBUF), .wr_idx(idx), .wr_data(h_wdata),
    .words(wbuf_words)
  );

  ipc_mbox_buf #(.DEPTH(NUM_WORDS), .DW(32)) u_rbuf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(c_rbuf_we), .wr_idx(c_rbuf_idx), .wr_data(c_rbuf_wdata),
    .words(rbuf_words)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sptr_q <= '0;
      dptr_q <= '0;
    end else if (full_wr) begin
      if (sel == SEL_SPTR) sptr_q <= h_wdata;
      if (sel == SEL_DPTR) dptr_q <= h_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_rdata <= '0;
    end else if (h_rd_en) begin
      case (sel)
        SEL_STAT: h_rdata <= stat_q;
        SEL_SPTR: h_rdata <= sptr_q;
        SEL_DPTR: h_rdata <= dptr_q;
        SEL_WBUF: h_rdata <= wbuf_words[idx];
        SEL_RBUF: h_rdata <= rbuf_words[idx];
        default:  h_rdata <= '0;
      endcase
    end
  end

  assign c_cmd       = cmd_q;
  assign c_sptr      = sptr_q;
  assign c_dptr      = dptr_q;
  assign c_wbuf_data = wbuf_words[c_wbuf_idx];
endmodule

// File: rtl/ipc_mbox_chk.sv
module ipc_mbox_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              h_wr_en,
  input logic [ADDR_W-1:0] h_addr,
  input logic [3:0]        h_be,
  input logic              c_busy,
  input logic              c_done,
  input logic              c_irq,
  input logic              c_irq_ack,
  input logic              h_irq,
  input logic [31:0]       c_cmd
);
  logic cmd_wr;
  assign cmd_wr = h_wr_en && (h_addr == '0) && (h_be == 4'hF);

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !c_busy) |=> (c_busy && c_irq));

  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_busy && !c_done) |=> c_busy);

  assert_irq_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_irq_ack && !(cmd_wr && !c_busy)) |=> !c_irq);

  assert_hirq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    h_irq |-> $past(c_done && c_busy));

  assert_hirq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    h_irq |=> !h_irq);

  assert_drop_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && c_busy) |=> $stable(c_cmd));
endmodule

bind ipc_mbox ipc_mbox_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_wr_en(h_wr_en), .h_addr(h_addr), .h_be(h_be),
  .c_busy(c_busy), .c_done(c_done), .c_irq(c_irq), .c_irq_ack(c_irq_ack),
  .h_irq(h_irq), .c_cmd(c_cmd)
);

// File: tb/ipc_mbox_tb.sv
`timescale 1ns/1ps
module ipc_mbox_tb_top;
  localparam logic [7:0] INIT = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_wr_en = 0, h_rd_en = 0;
  logic [7:0]  h_addr = 0;
  logic [3:0]  h_be = 0;
  logic [31:0] h_wdata = 0, h_rdata;
  logic        h_irq, c_irq, c_irq_ack = 0, c_busy;
  logic [31:0] c_cmd, c_sptr, c_dptr, c_wbuf_data;
  logic [1:0]  c_wbuf_idx = 0, c_rbuf_idx = 0;
  logic        c_rbuf_we = 0, c_done = 0, c_err = 0;
  logic [31:0] c_rbuf_wdata = 0;
  logic [7:0]  c_err_code = 0;
  int checks = 0, failures = 0;
  logic [31:0] rv, hold;

  always #4 clk = ~clk;

  ipc_mbox #(.INITIATOR_ID(INIT)) dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    h_wr_en = 1; h_addr = a; h_wdata = d; h_be = be;
    @(negedge clk); h_wr_en = 0; h_be = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    h_rd_en = 1; h_addr = a;
    @(negedge clk); h_rd_en = 0; d = h_rdata;
  endtask

  task automatic done(input logic e, input logic [7:0] code);
    c_done = 1; c_err = e; c_err_code = code;
    @(negedge clk); c_done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1", {29'd0, c_busy, c_irq, h_irq}, 32'd0);
    check("R1", h_rdata, 32'd0);
    rd(8'h04, rv); check("R1", rv, 32'd0);
    rd(8'h08, rv); check("R1", rv, 32'd0);
    rd(8'h9C, rv); check("R1", rv, 32'd0);
    // R10 pointers and input words
    wr(8'h08, 32'h1111_2222, 4'hF);
    wr(8'h0C, 32'h3333_4444, 4'hF);
    rd(8'h08, rv); check("R10", rv, 32'h1111_2222);
    rd(8'h0C, rv); check("R10", rv, 32'h3333_4444);
    check("R10", c_sptr, 32'h1111_2222);
    check("R10", c_dptr, 32'h3333_4444);
    for (int i = 0; i < 4; i++) wr(8'(8'h80 + 4*i), 32'hC0DE_0000 + 32'(i), 4'hF);
    for (int i = 0; i < 4; i++) begin
      rd(8'(8'h80 + 4*i), rv); check("R10", rv, 32'hC0DE_0000 + 32'(i));
      c_wbuf_idx = 2'(i); #1; check("R10", c_wbuf_data, 32'hC0DE_0000 + 32'(i));
    end
    // R7 partial writes ignored
    wr(8'h84, 32'hFFFF_FFFF, 4'h3);
    rd(8'h84, rv); check("R7", rv, 32'hC0DE_0001);
    wr(8'h08, 32'h0, 4'hE);
    rd(8'h08, rv); check("R7", rv, 32'h1111_2222);
    wr(8'h00, 32'h0000_0101, 4'h7);
    check("R7", {31'd0, c_busy}, 32'd0);
    // R11 read data holds without a read strobe
    rd(8'h0C, hold);
    wr(8'h0C, 32'hDEAD_BEEF, 4'hF);
    @(negedge clk); check("R11", h_rdata, hold);
    // R12 done while idle
    done(1'b1, 8'hEE);
    check("R12", {31'd0, h_irq}, 32'd0);
    rd(8'h04, rv); check("R12", rv, 32'd0);
    // sweep over sub-id and completion-interrupt bit
    for (int s = 0; s < 16; s++) begin
      for (int ioc = 0; ioc < 2; ioc++) begin
        logic [31:0] cw;
        logic [7:0]  code;
        logic        e;
        cw   = {8'h00, 8'(s + 1), 4'(s), 3'b000, 1'(ioc), 8'(8'h40 + s)};
        code = 8'(s * 7 + ioc);
        e    = 1'(s);
        wr(8'h00, cw, 4'hF);
        check("R2", c_cmd, cw);
        check("R2", {30'd0, c_busy, c_irq}, 32'd3);
        rd(8'h04, rv); check("R2", rv & 32'h5, 32'h1);
        rd(8'h00, rv); check("R8", rv, 32'd0);
        c_irq_ack = 1; @(negedge clk); c_irq_ack = 0;
        check("R4", {31'd0, c_irq}, 32'd0);
        c_rbuf_we = 1; c_rbuf_idx = 2'(s); c_rbuf_wdata = 32'hA500_0000 + 32'(s * 2 + ioc);
        @(negedge clk); c_rbuf_we = 0;
        done(e, code);
        check("R5", {31'd0, h_irq}, 32'(ioc));
        check("R3", {31'd0, c_busy}, 32'd0);
        @(negedge clk); check("R5", {31'd0, h_irq}, 32'd0);
        rd(8'h04, rv);
        check("R3", rv, {8'h00, code, INIT, 4'(s), 2'b00, e, 1'b0});
        rd(8'(8'h90 + 4 * (s % 4)), rv);
        check("R10", rv, 32'hA500_0000 + 32'(s * 2 + ioc));
      end
    end
    // R9 host writes to status and reply words ignored
    rd(8'h04, hold);
    wr(8'h04, 32'hFFFF_FFFF, 4'hF);
    rd(8'h04, rv); check("R9", rv, hold);
    rd(8'h9C, hold);
    wr(8'h9C, 32'h1234_5678, 4'hF);
    rd(8'h9C, rv); check("R9", rv, hold);
    // R8 unmapped and misaligned reads
    for (int w = 4; w < 64; w++) begin
      if (w < 32 || w >= 40) begin
        rd(8'(w * 4), rv); check("R8", rv, 32'd0);
      end
    end
    rd(8'h0A, rv); check("R8", rv, 32'd0);
    // R6 command while busy dropped, sticky overrun
    wr(8'h00, 32'h0000_1077, 4'hF);
    wr(8'h00, 32'h0000_2088, 4'hF);
    check("R6", c_cmd, 32'h0000_1077);
    rd(8'h04, rv); check("R6", rv & 32'h5, 32'h5);
    done(1'b0, 8'h00);
    wr(8'h00, 32'h0000_3099, 4'hF);
    check("R6", c_cmd, 32'h0000_3099);
    rd(8'h04, rv); check("R6", rv & 32'h5, 32'h5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule